// File: doc/BRIEF.md
# Temperature Window Comparator with Hysteresis

This block watches a stream of signed temperature samples and keeps three status flags: one for a sample above a programmable upper limit, one for a sample below a programmable lower limit, and one for a sample at or over a critical limit. Each flag sets at one threshold and clears at another. The gap between the two is a hysteresis amount chosen by a 2-bit code, so a temperature sitting on a limit does not make the flag chatter. An event output is formed from the flags. It can be enabled, inverted, restricted to the critical flag only, and run either as a level that follows the flags or as a latch that software clears.

Software reaches the block through a plain register port: an address, write data and a write strobe, with read data returned combinationally. The registers are a 16-bit configuration word, the three limits and a read-only status word. Two lock bits in the configuration word protect the hysteresis code from being rewritten. A shutdown bit stops the block from taking new samples.

Temperatures and limits are 13-bit two's complement values, one LSB per 0.125 °C.

Top module: `thermWindowCmp`

## Requirements
- R1: After reset the configuration word, the limits, the stored temperature and all three flags are 0, and `evtOut` is 0.
- R2: Configuration bits 15:11 read as 0 and ignore writes. Bit 5 (clear-event) always reads as 0. Register addresses: 0 configuration, 1 upper limit, 2 lower limit, 3 critical limit, 4 status.
- R3: The hysteresis code in configuration bits 10:9 selects 0, 12, 24 or 48 LSB for codes 00, 01, 10 and 11.
- R4: On a taken sample T, the above flag sets when T > upper. It clears when T <= upper − hysteresis. Otherwise it holds.
- R5: On a taken sample, the below flag clears when T >= lower. It sets when T <= lower − hysteresis. The clear test wins when both hold, so with zero hysteresis T = lower leaves the flag at 0. Comparisons are signed.
- R6: On a taken sample, the critical flag sets when T >= critical. It clears when T < critical − hysteresis.
- R7: While configuration bit 7 (critical lock) or bit 6 (window lock) holds 1 before a write, that write leaves bits 10:9 unchanged and still updates the other writable bits.
- R8: Flags and stored temperature change only on a clock edge where `sampleValid` is 1 and shutdown (configuration bit 8) is 0.
- R9: With event mode (bit 0) at 0, the event condition is the critical flag when bit 2 is 1, else the OR of the above and below flags. `evtOut` = (enable bit 3 AND condition) XOR polarity bit 1. Status bit 4 of the configuration read shows the condition.
- R10: With event mode 1, the event condition is a latch. The latch sets on a taken sample whose new flags meet the selected condition. It clears when the configuration is written with bit 5 at 1. A set on the same edge as a clear wins.
- R11: A read of address 4 returns the critical flag in bit 15, the above flag in bit 14, the below flag in bit 13 and the stored temperature in bits 12:0.
- R12: Writes to addresses 1 to 3 keep write-data bits 12:0. Reads of those addresses return the limit with bits 15:13 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Register write data |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| sampleValid | input | 1 | Temperature sample strobe |
| sampleTemp | input | 13 | Signed temperature sample |
| aboveWin | output | 1 | Above-window flag |
| belowWin | output | 1 | Below-window flag |
| critTrip | output | 1 | Critical flag |
| evtOut | output | 1 | Event output |

## Verification
The flags are state that persists through the hysteresis band, so an error in a flag or a threshold stays hidden until a sample lands inside the band. Once it does, the flag pin shows a wrong value one edge after that sample, and it keeps showing it. The stimulus therefore places samples exactly on each set and clear threshold, and one LSB to either side, under every hysteresis code.

A wrong lock or hysteresis code shows up at once in the configuration read-back. A stale event latch shows on `evtOut` right after the edge that should have cleared or set it.

// File: rtl/thermPkg.sv
package thermPkg;

  // register addresses (status sits after the three limits)
  localparam int unsigned ADDR_CFG    = 0;
  localparam int unsigned ADDR_UPPER  = 1;
  localparam int unsigned ADDR_LOWER  = 2;
  localparam int unsigned ADDR_CRIT   = 3;
  localparam int unsigned ADDR_STATUS = 4;

  // configuration bit positions
  localparam int unsigned CFG_MODE     = 0;
  localparam int unsigned CFG_POL      = 1;
  localparam int unsigned CFG_CRITONLY = 2;
  localparam int unsigned CFG_EN       = 3;
  localparam int unsigned CFG_STAT     = 4;
  localparam int unsigned CFG_CLR      = 5;
  localparam int unsigned CFG_WLOCK    = 6;
  localparam int unsigned CFG_CLOCK    = 7;
  localparam int unsigned CFG_SHDN     = 8;
  localparam int unsigned CFG_HYST_LO  = 9;
  localparam int unsigned CFG_HYST_HI  = 10;

  typedef struct packed {
    logic       shutdown;
    logic       critLock;
    logic       winLock;
    logic       evtEn;
    logic       critOnly;
    logic       polarity;
    logic       evtMode;
    logic [1:0] hystSel;
  } cfg_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic wrCrit;
    logic clearEvt;
    logic takeSample;
  } strobe_t;

endpackage

// File: rtl/thermCtrl.sv
module thermCtrl
  import thermPkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] upperLim,
  input  logic [TEMP_W-1:0] lowerLim,
  input  logic [TEMP_W-1:0] critLim,
  input  logic [TEMP_W-1:0] tempReg,
  input  logic              aboveFlag,
  input  logic              belowFlag,
  input  logic              critFlag,
  input  logic              evtActive,
  output cfg_t              cfg,
  output strobe_t           strobe,
  output logic [DATA_W-1:0] regRdData
);

  localparam int unsigned PAD_W = DATA_W - TEMP_W;

  cfg_t cfgQ;
  logic cfgWrite;
  logic lockActive;

  always_comb begin
    cfgWrite   = regWrEn && (regAddr == ADDR_W'(ADDR_CFG));
    lockActive = cfgQ.critLock | cfgQ.winLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrite) begin
      cfgQ.shutdown <= regWrData[CFG_SHDN];
      cfgQ.critLock <= regWrData[CFG_CLOCK];
      cfgQ.winLock  <= regWrData[CFG_WLOCK];
      cfgQ.evtEn    <= regWrData[CFG_EN];
      cfgQ.critOnly <= regWrData[CFG_CRITONLY];
      cfgQ.polarity <= regWrData[CFG_POL];
      cfgQ.evtMode  <= regWrData[CFG_MODE];
      if (!lockActive) begin
        cfgQ.hystSel <= regWrData[CFG_HYST_HI:CFG_HYST_LO];
      end
    end
  end

  assign cfg = cfgQ;

  always_comb begin
    strobe.wrUpper    = regWrEn && (regAddr == ADDR_W'(ADDR_UPPER));
    strobe.wrLower    = regWrEn && (regAddr == ADDR_W'(ADDR_LOWER));
    strobe.wrCrit     = regWrEn && (regAddr == ADDR_W'(ADDR_CRIT));
    strobe.clearEvt   = cfgWrite && regWrData[CFG_CLR];
    strobe.takeSample = sampleValid && !cfgQ.shutdown;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CFG): begin
        regRdData[CFG_HYST_HI:CFG_HYST_LO] = cfgQ.hystSel;
        regRdData[CFG_SHDN]     = cfgQ.shutdown;
        regRdData[CFG_CLOCK]    = cfgQ.critLock;
        regRdData[CFG_WLOCK]    = cfgQ.winLock;
        regRdData[CFG_STAT]     = evtActive;
        regRdData[CFG_EN]       = cfgQ.evtEn;
        regRdData[CFG_CRITONLY] = cfgQ.critOnly;
        regRdData[CFG_POL]      = cfgQ.polarity;
        regRdData[CFG_MODE]     = cfgQ.evtMode;
      end
      ADDR_W'(ADDR_UPPER): regRdData = {{PAD_W{1'b0}}, upperLim};
      ADDR_W'(ADDR_LOWER): regRdData = {{PAD_W{1'b0}}, lowerLim};
      ADDR_W'(ADDR_CRIT):  regRdData = {{PAD_W{1'b0}}, critLim};
      ADDR_W'(ADDR_STATUS): begin
        regRdData[DATA_W-1]   = critFlag;
        regRdData[DATA_W-2]   = aboveFlag;
        regRdData[DATA_W-3]   = belowFlag;
        regRdData[TEMP_W-1:0] = tempReg;
      end
      default: regRdData = '0;
    endcase
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[DATA_W-1:CFG_HYST_HI+1], regWrData[CFG_STAT]};

  AST_HYST_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && lockActive) |=> $stable(cfgQ.hystSel)); // R7

  AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_CFG)) |-> (regRdData[DATA_W-1:CFG_HYST_HI+1] == '0 && !regRdData[CFG_CLR])); // R2

endmodule

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
#(
  parameter int unsigned TEMP_W    = 13,
  parameter int unsigned HYST_UNIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  cfg_t              cfg,
  input  logic [TEMP_W-1:0] limData,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic [TEMP_W-1:0] upperLim,
  output logic [TEMP_W-1:0] lowerLim,
  output logic [TEMP_W-1:0] critLim,
  output logic [TEMP_W-1:0] tempReg,
  output logic              aboveFlag,
  output logic              belowFlag,
  output logic              critFlag,
  output logic              evtActive,
  output logic              evtOut
);

  localparam int unsigned WIDE_W    = TEMP_W + 2;
  localparam int unsigned HYST_CODES = 4;

  // hysteresis table: code 0 is zero, each later code doubles the unit
  logic signed [WIDE_W-1:0] hystTable [HYST_CODES];
  for (genvar i = 0; i < HYST_CODES; i++) begin : g_hyst
    if (i == 0) begin : g_zero
      assign hystTable[i] = '0;
    end else begin : g_step
      assign hystTable[i] = WIDE_W'(HYST_UNIT << (i - 1));
    end
  end

  // limit registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperLim <= '0;
      lowerLim <= '0;
      critLim  <= '0;
    end else begin
      if (strobe.wrUpper) upperLim <= limData;
      if (strobe.wrLower) lowerLim <= limData;
      if (strobe.wrCrit)  critLim  <= limData;
    end
  end

  // sign-extended operands
  logic signed [WIDE_W-1:0] sT, upW, loW, crW, hW;
  always_comb begin
    sT  = {{2{sampleTemp[TEMP_W-1]}}, sampleTemp};
    upW = {{2{upperLim[TEMP_W-1]}}, upperLim};
    loW = {{2{lowerLim[TEMP_W-1]}}, lowerLim};
    crW = {{2{critLim[TEMP_W-1]}}, critLim};
    hW  = hystTable[cfg.hystSel];
  end

  // next flag values: set and clear thresholds differ by the hysteresis
  logic aboveNext, belowNext, critNext;
  always_comb begin
    if (sT > upW)             aboveNext = 1'b1;
    else if (sT <= upW - hW)  aboveNext = 1'b0;
    else                      aboveNext = aboveFlag;

    if (sT >= loW)            belowNext = 1'b0;
    else if (sT <= loW - hW)  belowNext = 1'b1;
    else                      belowNext = belowFlag;

    if (sT >= crW)            critNext = 1'b1;
    else if (sT < crW - hW)   critNext = 1'b0;
    else                      critNext = critFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aboveFlag <= 1'b0;
      belowFlag <= 1'b0;
      critFlag  <= 1'b0;
      tempReg   <= '0;
    end else if (strobe.takeSample) begin
      aboveFlag <= aboveNext;
      belowFlag <= belowNext;
      critFlag  <= critNext;
      tempReg   <= sampleTemp;
    end
  end

  // event condition and latch
  logic rawNow, rawNext, evtLatch;
  always_comb begin
    rawNow  = cfg.critOnly ? critFlag : (aboveFlag | belowFlag);
    rawNext = cfg.critOnly ? critNext : (aboveNext | belowNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtLatch <= 1'b0;
    end else begin
      evtLatch <= (strobe.clearEvt ? 1'b0 : evtLatch) | (strobe.takeSample & rawNext);
    end
  end

  always_comb begin
    evtActive = cfg.evtMode ? evtLatch : rawNow;
    evtOut    = (cfg.evtEn & evtActive) ^ cfg.polarity;
  end

  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfg.shutdown, cfg.critLock, cfg.winLock};

  AST_ABOVE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSample && sT > upW) |=> aboveFlag); // R4
  AST_ABOVE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSample && sT <= upW - hW) |=> !aboveFlag); // R4
  AST_BELOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSample && sT >= loW) |=> !belowFlag); // R5
  AST_CRIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSample && sT >= crW) |=> critFlag); // R6
  AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSample |=> $stable({aboveFlag, belowFlag, critFlag, tempReg})); // R8
  AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearEvt && !strobe.takeSample) |=> !evtLatch); // R10

endmodule

// File: rtl/thermWindowCmp.sv
module thermWindowCmp
  import thermPkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned TEMP_W    = 13,
  parameter int unsigned HYST_UNIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic              aboveWin,
  output logic              belowWin,
  output logic              critTrip,
  output logic              evtOut
);

  cfg_t              cfg;
  strobe_t           strobe;
  logic [TEMP_W-1:0] upperLim, lowerLim, critLim, tempReg;
  logic              evtActive;

  thermCtrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TEMP_W(TEMP_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .sampleValid(sampleValid),
    .upperLim   (upperLim),
    .lowerLim   (lowerLim),
    .critLim    (critLim),
    .tempReg    (tempReg),
    .aboveFlag  (aboveWin),
    .belowFlag  (belowWin),
    .critFlag   (critTrip),
    .evtActive  (evtActive),
    .cfg        (cfg),
    .strobe     (strobe),
    .regRdData  (regRdData)
  );

  thermDatapath #(
    .TEMP_W   (TEMP_W),
    .HYST_UNIT(HYST_UNIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfg       (cfg),
    .limData   (regWrData[TEMP_W-1:0]),
    .sampleTemp(sampleTemp),
    .upperLim  (upperLim),
    .lowerLim  (lowerLim),
    .critLim   (critLim),
    .tempReg   (tempReg),
    .aboveFlag (aboveWin),
    .belowFlag (belowWin),
    .critFlag  (critTrip),
    .evtActive (evtActive),
    .evtOut    (evtOut)
  );

endmodule

// File: tb/thermWindowCmp_bench.sv
module thermWindowCmp_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regRdData;
  logic        sampleValid = 1'b0;
  logic [12:0] sampleTemp = '0;
  logic        aboveWin, belowWin, critTrip, evtOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  thermWindowCmp u_thermWindowCmp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .sampleValid(sampleValid),
    .sampleTemp(sampleTemp), .aboveWin(aboveWin), .belowWin(belowWin),
    .critTrip(critTrip), .evtOut(evtOut)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic smp(logic [12:0] t);
    @(negedge clk);
    sampleTemp = t; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] d;
    check("R1 flags after reset", {13'd0, aboveWin, belowWin, critTrip}, 16'd0);
    check("R1 evtOut after reset", {15'd0, evtOut}, 16'd0);
    rd(3'd0, d); check("R1 config after reset", d, 16'h0000);
    rd(3'd4, d); check("R1 status after reset", d, 16'h0000);
  endtask

  task automatic tReserved();
    logic [15:0] d;
    wr(3'd0, 16'hF800); rd(3'd0, d); check("R2 reserved bits read 0", d, 16'h0000);
    wr(3'd0, 16'h0020); rd(3'd0, d); check("R2 clear bit reads 0", d, 16'h0000);
    rd(3'd6, d); check("R2 unmapped address reads 0", d, 16'h0000);
  endtask

  task automatic tLimits();
    logic [15:0] d;
    wr(3'd1, 16'hE190); rd(3'd1, d); check("R12 upper keeps 13 bits", d, 16'h0190);
    wr(3'd2, 16'd100);  rd(3'd2, d); check("R12 lower readback", d, 16'd100);
    wr(3'd3, 16'd600);  rd(3'd3, d); check("R12 critical readback", d, 16'd600);
  endtask

  task automatic tAboveNoHyst();
    logic [15:0] d;
    smp(13'd401); check("R4 above sets over upper", {15'd0, aboveWin}, 16'd1);
    rd(3'd4, d); check("R11 status layout", d, 16'h4191);
    smp(13'd400); check("R4 above clears at upper, no hysteresis", {15'd0, aboveWin}, 16'd0);
  endtask

  task automatic tAboveHyst24();
    wr(3'd0, 16'h0400);
    smp(13'd401); check("R3 above sets code 10", {15'd0, aboveWin}, 16'd1);
    smp(13'd377); check("R3 above holds at upper-23", {15'd0, aboveWin}, 16'd1);
    smp(13'd376); check("R4 above clears at upper-24", {15'd0, aboveWin}, 16'd0);
  endtask

  task automatic tBelowHyst12();
    wr(3'd0, 16'h0200);
    smp(13'd150); check("R5 below clear above lower", {15'd0, belowWin}, 16'd0);
    smp(13'd89);  check("R3 below not set at lower-11", {15'd0, belowWin}, 16'd0);
    smp(13'd88);  check("R5 below sets at lower-12", {15'd0, belowWin}, 16'd1);
    smp(13'd99);  check("R5 below holds under lower", {15'd0, belowWin}, 16'd1);
    smp(13'd100); check("R5 below clears at lower", {15'd0, belowWin}, 16'd0);
  endtask

  task automatic tBelowNoHyst();
    wr(3'd0, 16'h0000);
    smp(13'd100); check("R5 below stays 0 at lower, zero hysteresis", {15'd0, belowWin}, 16'd0);
    smp(13'd99);  check("R5 below sets one under lower", {15'd0, belowWin}, 16'd1);
    smp(13'd100); check("R5 below clears at lower", {15'd0, belowWin}, 16'd0);
    wr(3'd2, 16'h1FD8);
    smp(13'h1FD8); check("R5 signed: at -40 not below", {15'd0, belowWin}, 16'd0);
    smp(13'h1FD7); check("R5 signed: -41 below -40", {15'd0, belowWin}, 16'd1);
    wr(3'd2, 16'd100);
  endtask

  task automatic tCritHyst48();
    wr(3'd0, 16'h0600);
    smp(13'd599); check("R6 crit not set under limit", {15'd0, critTrip}, 16'd0);
    smp(13'd600); check("R6 crit sets at limit", {15'd0, critTrip}, 16'd1);
    smp(13'd552); check("R3 crit holds at limit-48", {15'd0, critTrip}, 16'd1);
    smp(13'd551); check("R6 crit clears under limit-48", {15'd0, critTrip}, 16'd0);
    smp(13'd200);
    wr(3'd0, 16'h0000);
    check("R4 settle flags", {13'd0, aboveWin, belowWin, critTrip}, 16'd0);
  endtask

  task automatic tLock();
    logic [15:0] d;
    wr(3'd0, 16'h0240); rd(3'd0, d); check("R7 lock and code written together", d, 16'h0240);
    wr(3'd0, 16'h0640); rd(3'd0, d); check("R7 window lock holds code", d, 16'h0240);
    wr(3'd0, 16'h0000); rd(3'd0, d); check("R7 unlock write keeps code", d, 16'h0200);
    wr(3'd0, 16'h0680); rd(3'd0, d); check("R7 code written while unlocked", d, 16'h0680);
    wr(3'd0, 16'h0082); rd(3'd0, d); check("R7 critical lock holds code, other bits written", d, 16'h0682);
    wr(3'd0, 16'h0000); wr(3'd0, 16'h0000);
    rd(3'd0, d); check("R7 code cleared after unlock", d, 16'h0000);
  endtask

  task automatic tValidShutdown();
    logic [15:0] d;
    @(negedge clk);
    sampleTemp = 13'd1000;
    repeat (3) @(negedge clk);
    check("R8 no valid, flags hold", {13'd0, aboveWin, belowWin, critTrip}, 16'd0);
    rd(3'd4, d); check("R8 no valid, temperature holds", d, 16'd200);
    wr(3'd0, 16'h0100);
    smp(13'd1000);
    check("R8 shutdown freezes flags", {13'd0, aboveWin, belowWin, critTrip}, 16'd0);
    rd(3'd4, d); check("R8 shutdown freezes temperature", d, 16'd200);
    wr(3'd0, 16'h0000);
    smp(13'd1000);
    check("R8 sample taken after shutdown", {13'd0, aboveWin, belowWin, critTrip}, 16'h0005);
    smp(13'd200);
  endtask

  task automatic tEventLevel();
    logic [15:0] d;
    wr(3'd0, 16'h0008); check("R9 enabled, no condition", {15'd0, evtOut}, 16'd0);
    smp(13'd401); check("R9 above drives event", {15'd0, evtOut}, 16'd1);
    rd(3'd0, d); check("R9 status bit shows condition", d, 16'h0018);
    wr(3'd0, 16'h000A); check("R9 polarity inverts", {15'd0, evtOut}, 16'd0);
    wr(3'd0, 16'h000C); check("R9 critical-only masks window", {15'd0, evtOut}, 16'd0);
    wr(3'd0, 16'h0002); check("R9 disabled with polarity 1", {15'd0, evtOut}, 16'd1);
    wr(3'd0, 16'h0000); check("R9 disabled", {15'd0, evtOut}, 16'd0);
    smp(13'd50);
    wr(3'd0, 16'h0008); check("R9 below drives event", {15'd0, evtOut}, 16'd1);
    smp(13'd200); check("R9 event follows flags", {15'd0, evtOut}, 16'd0);
  endtask

  task automatic tEventLatch();
    logic [15:0] d;
    wr(3'd0, 16'h0029); check("R10 latch cleared on entry", {15'd0, evtOut}, 16'd0);
    smp(13'd401); check("R10 latch sets", {15'd0, evtOut}, 16'd1);
    smp(13'd200); check("R10 latch holds after condition ends", {15'd0, evtOut}, 16'd1);
    rd(3'd0, d); check("R10 status shows latch", d, 16'h0019);
    wr(3'd0, 16'h0029); check("R10 clear write", {15'd0, evtOut}, 16'd0);
    smp(13'd200); check("R10 no condition, stays clear", {15'd0, evtOut}, 16'd0);
    smp(13'd401);
    wr(3'd0, 16'h0029); check("R10 clear while above", {15'd0, evtOut}, 16'd0);
    @(negedge clk);
    regAddr = 3'd0; regWrData = 16'h0029; regWrEn = 1'b1;
    sampleTemp = 13'd402; sampleValid = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; sampleValid = 1'b0;
    check("R10 set wins over clear", {15'd0, evtOut}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReserved();
    tLimits();
    tAboveNoHyst();
    tAboveHyst24();
    tBelowHyst12();
    tBelowNoHyst();
    tCritHyst48();
    tLock();
    tValidShutdown();
    tEventLevel();
    tEventLatch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule